// File: doc/BRIEF.md
# Delay-Line Output Queue Scheduler

This block is the electronic slot controller of an output-queued packet switch. The switch has no memory. Its buffer is a bank of fixed delay modules, and module k holds a packet for exactly k slots. In every slot each of the N switch inputs may present one arrival request, made of a valid bit and a 1-based destination output. The scheduler keeps one occupancy count per output and uses it to give each arrival a delay. An arrival whose output queue is empty, and which is first in line, takes the direct path with delay 0. Other arrivals receive the next free delay behind the packets already waiting. An arrival that would need a delay beyond the largest module is dropped.

For every buffered packet the block issues a scheduling wavelength index. That index steers the packet through a cyclic router of size 2N to the chosen delay module. The N real ports sit on router ports N+1..2N and the modules on router ports 1..N. Each return command waits in a pipeline indexed by remaining delay. When its delay has elapsed, the block issues a switching wavelength index toward the destination, on the same switch input the packet entered on. Direct packets get their switching index in the slot they arrive.

Each output queue is a small state machine with three states. Q_EMPTY means occupancy is zero and direct service is possible. Q_BUSY means occupancy is between 1 and N-1. Q_FULL means occupancy equals N. The transitions are fill (Q_EMPTY to Q_BUSY), drain (Q_BUSY to Q_EMPTY), saturate (Q_BUSY to Q_FULL) and release (Q_FULL to Q_BUSY). A queue in any other case stays in its state.

Top module: `dlb_sched`

## Requirements
- R1: After reset every queue is empty, no return command is valid, and with no requests nothing is accepted.
- R2: A request with its valid bit low, or with a destination outside 1..N, is neither accepted nor dropped, and all of its per-input outputs stay zero.
- R3: Requests for the same output in one slot are served in ascending input order. The r-th of them (r counted from 0) gets delay Q+r, where Q is that output's occupancy at the end of the previous slot.
- R4: An accepted request with delay 0 raises `direct` and not `sched_vld`. Every accepted request with a delay from 1 to N raises `sched_vld` and not `direct`.
- R5: Per output, occupancy follows Q_new = min(max(0, Q + X - 1), N), where X is the number of requests for that output in the slot, dropped ones included.
- R6: A request whose delay would exceed N raises `drop` and not `acc`. So Q + X - 1 - N requests are dropped when that number is positive. `acc` and `drop` are never both high.
- R7: For an accepted request on switch input i (1-based) with delay k ≥ 1, `sched_wl` = 1 + ((N + i + k - 2) mod 2N). The value is 0 when `sched_vld` is low.
- R8: For a direct request from input i to output j, `dir_wl` = 1 + ((i + j - 2) mod N). The value is 0 when `direct` is low.
- R9: A request accepted with delay k ≥ 1 in slot t raises `rtn_vld[j-1]` during slot t+k. In that slot `rtn_src` holds i and `rtn_wl` = 1 + ((i + j - 2) mod N). Both fields are 0 when `rtn_vld` is low.
- R10: `dly` carries the assigned delay of an accepted request and is 0 otherwise. It never exceeds N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one edge per slot |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_vld | input | N | Request valid, bit i for switch input i+1 |
| arr_dst | input | N*IW | 1-based destination for input i+1 in bits [i*IW +: IW] |
| acc | output | N | Request accepted this slot |
| drop | output | N | Request dropped on overflow |
| direct | output | N | Accepted with delay 0 (direct path) |
| sched_vld | output | N | Accepted into a delay module |
| dly | output | N*DW | Assigned delay per input, field [i*DW +: DW] |
| sched_wl | output | N*SW | Scheduling wavelength index per input, field [i*SW +: SW] |
| dir_wl | output | N*IW | Switching wavelength index for direct packets, field [i*IW +: IW] |
| rtn_vld | output | N | Buffered packet returns this slot, bit j for output j+1 |
| rtn_src | output | N*IW | 1-based switch input of the returning packet, field [j*IW +: IW] |
| rtn_wl | output | N*IW | Switching wavelength index of the returning packet, field [j*IW +: IW] |

## Verification
The bench builds the block with N = 4, so IW = 3, DW = 3, SW = 4 and the scheduling router has 8 ports. With N this small, a burst of four requests to one output, followed by a second burst, reaches a full queue in two slots. That brings the saturate, release and drop paths within reach quickly. The delay range 1..4 also covers both wrap-arounds of the modulo-8 and modulo-4 wavelength rules. A 3-bit destination field can encode 0, 5, 6 and 7, which lets the bench feed out-of-range destinations alongside legal ones. Random traffic then mixes these cases while the reference queues predict every port on every slot.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    // Per-output queue condition
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_BUSY  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;

endpackage

// File: rtl/dlb_outq.sv
// One output queue: occupancy FSM plus delay assignment for the requests aimed at it.
module dlb_outq
    import dlb_pkg::*;
#(
    parameter int N  = 4,
    parameter int W  = $clog2(N),
    parameter int DW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   hit,
    output logic [N-1:0]   acc,
    output logic [N-1:0]   drop,
    output logic [N-1:0]   direct,
    output logic [N*DW-1:0] dly,
    output logic [N-1:0]   ins_v,
    output logic [N*W-1:0] ins_s
);

    qstate_e        st_q, st_d;
    logic [DW-1:0]  occ_q, occ_d;
    int             arrivals;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= Q_EMPTY;
            occ_q <= '0;
        end else begin
            st_q  <= st_d;
            occ_q <= occ_d;
        end
    end

    // Output process: delays in ascending input order from the current base
    always_comb begin
        int pos;
        acc      = '0;
        drop     = '0;
        direct   = '0;
        dly      = '0;
        ins_v    = '0;
        ins_s    = '0;
        arrivals = 0;
        unique case (st_q)
            Q_EMPTY: pos = 0;
            Q_BUSY,
            Q_FULL:  pos = int'(occ_q);
            default: pos = int'(occ_q);
        endcase
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                arrivals = arrivals + 1;
                if (pos <= N) begin
                    acc[i]          = 1'b1;
                    dly[i*DW +: DW] = DW'(pos);
                    if (pos == 0) begin
                        direct[i] = 1'b1;
                    end else begin
                        ins_v[pos-1]         = 1'b1;
                        ins_s[(pos-1)*W +: W] = W'(i);
                    end
                end else begin
                    drop[i] = 1'b1;
                end
                pos = pos + 1;
            end
        end
    end

    // Next occupancy and named transitions
    always_comb begin
        int nxt;
        nxt = int'(occ_q) + arrivals - 1;
        if (nxt < 0) nxt = 0;
        if (nxt > N) nxt = N;
        occ_d = DW'(nxt);
        st_d  = st_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (nxt > 0) st_d = Q_BUSY;        // fill
            end
            Q_BUSY: begin
                if (nxt == 0)      st_d = Q_EMPTY; // drain
                else if (nxt == N) st_d = Q_FULL;  // saturate
            end
            Q_FULL: begin
                if (nxt < N) st_d = Q_BUSY;        // release
            end
            default: st_d = Q_EMPTY;
        endcase
    end

endmodule

// File: rtl/dlb_retpipe.sv
// Return pipeline for one output, indexed by remaining delay (stage 0 = due now).
module dlb_retpipe #(
    parameter int N = 4,
    parameter int W = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   ins_v,
    input  logic [N*W-1:0] ins_s,
    output logic           out_v,
    output logic [W-1:0]   out_s
);

    logic [N-1:0]   v_q, v_d;
    logic [N*W-1:0] s_q, s_d;

    always_comb begin
        logic [N-1:0]   v_sh;
        logic [N*W-1:0] s_sh;
        v_sh = v_q >> 1;
        s_sh = s_q >> W;
        for (int k = 0; k < N; k++) begin
            v_d[k]         = ins_v[k] | v_sh[k];
            s_d[k*W +: W]  = ins_v[k] ? ins_s[k*W +: W] : s_sh[k*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            s_q <= '0;
        end else begin
            v_q <= v_d;
            s_q <= s_d;
        end
    end

    assign out_v = v_q[0];
    assign out_s = v_q[0] ? s_q[W-1:0] : '0;

endmodule

// File: rtl/dlb_wlmap.sv
// Cyclic router index arithmetic for scheduling and switching converters.
module dlb_wlmap #(
    parameter int N  = 4,
    parameter int W  = $clog2(N),
    parameter int DW = $clog2(N + 1),
    parameter int IW = $clog2(N + 1),
    parameter int SW = $clog2(2 * N + 1)
) (
    input  logic [N-1:0]    sched_v,
    input  logic [N*DW-1:0] dly,
    input  logic [N-1:0]    direct,
    input  logic [N*W-1:0]  dst0,
    input  logic [N-1:0]    rtn_v,
    input  logic [N*W-1:0]  rtn_s0,
    output logic [N*SW-1:0] sched_wl,
    output logic [N*IW-1:0] dir_wl,
    output logic [N*IW-1:0] rtn_wl
);

    localparam int P = 2 * N;

    for (genvar g = 0; g < N; g++) begin : g_map
        // router port of switch input g is N+g+1; delay module k is router port k
        assign sched_wl[g*SW +: SW] = sched_v[g]
            ? SW'(((N + g + int'(dly[g*DW +: DW]) - 1) % P) + 1) : '0;
        assign dir_wl[g*IW +: IW] = direct[g]
            ? IW'(((g + int'(dst0[g*W +: W])) % N) + 1) : '0;
        assign rtn_wl[g*IW +: IW] = rtn_v[g]
            ? IW'(((int'(rtn_s0[g*W +: W]) + g) % N) + 1) : '0;
    end

endmodule

// File: rtl/dlb_sched.sv
// Slot scheduler for a delay-module buffered, output-queued switch.
module dlb_sched #(
    parameter int N  = 4,
    parameter int IW = $clog2(N + 1),
    parameter int DW = $clog2(N + 1),
    parameter int SW = $clog2(2 * N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    arr_vld,
    input  logic [N*IW-1:0] arr_dst,
    output logic [N-1:0]    acc,
    output logic [N-1:0]    drop,
    output logic [N-1:0]    direct,
    output logic [N-1:0]    sched_vld,
    output logic [N*DW-1:0] dly,
    output logic [N*SW-1:0] sched_wl,
    output logic [N*IW-1:0] dir_wl,
    output logic [N-1:0]    rtn_vld,
    output logic [N*IW-1:0] rtn_src,
    output logic [N*IW-1:0] rtn_wl
);

    localparam int W = $clog2(N);

    logic [N-1:0]    req_ok;
    logic [N*W-1:0]  dst0;
    logic [N-1:0]    hit    [N];
    logic [N-1:0]    acc_m  [N];
    logic [N-1:0]    drop_m [N];
    logic [N-1:0]    dir_m  [N];
    logic [N*DW-1:0] dly_m  [N];
    logic [N-1:0]    insv_m [N];
    logic [N*W-1:0]  inss_m [N];
    logic [N*W-1:0]  rtn_s0;

    // Request decode: 1-based destination to 0-based index
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic [IW-1:0] d;
            d = arr_dst[i*IW +: IW];
            req_ok[i]       = arr_vld[i] && (d != '0) && (int'(d) <= N);
            dst0[i*W +: W]  = W'(d - IW'(1));
        end
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                hit[j][i] = req_ok[i] && (int'(dst0[i*W +: W]) == j);
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        dlb_outq #(.N(N), .W(W), .DW(DW)) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit[j]),
            .acc    (acc_m[j]),
            .drop   (drop_m[j]),
            .direct (dir_m[j]),
            .dly    (dly_m[j]),
            .ins_v  (insv_m[j]),
            .ins_s  (inss_m[j])
        );
        dlb_retpipe #(.N(N), .W(W)) u_rp (
            .clk   (clk),
            .rst_n (rst_n),
            .ins_v (insv_m[j]),
            .ins_s (inss_m[j]),
            .out_v (rtn_vld[j]),
            .out_s (rtn_s0[j*W +: W])
        );
        assign rtn_src[j*IW +: IW] = rtn_vld[j] ? IW'(rtn_s0[j*W +: W]) + IW'(1) : '0;
    end

    // Each input belongs to at most one output, so OR-merge is exact
    always_comb begin
        acc    = '0;
        drop   = '0;
        direct = '0;
        dly    = '0;
        for (int j = 0; j < N; j++) begin
            acc    = acc    | acc_m[j];
            drop   = drop   | drop_m[j];
            direct = direct | dir_m[j];
            dly    = dly    | dly_m[j];
        end
    end

    assign sched_vld = acc & ~direct;

    dlb_wlmap #(.N(N), .W(W), .DW(DW), .IW(IW), .SW(SW)) u_wl (
        .sched_v  (sched_vld),
        .dly      (dly),
        .direct   (direct),
        .dst0     (dst0),
        .rtn_v    (rtn_vld),
        .rtn_s0   (rtn_s0),
        .sched_wl (sched_wl),
        .dir_wl   (dir_wl),
        .rtn_wl   (rtn_wl)
    );

endmodule

// File: rtl/dlb_sched_chk.sv
module dlb_sched_chk #(
    parameter int N  = 4,
    parameter int IW = $clog2(N + 1),
    parameter int DW = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    arr_vld,
    input logic [N*IW-1:0] arr_dst,
    input logic [N-1:0]    acc,
    input logic [N-1:0]    drop,
    input logic [N-1:0]    direct,
    input logic [N-1:0]    sched_vld,
    input logic [N*DW-1:0] dly,
    input logic [N-1:0]    rtn_vld
);

    logic [N-1:0] one_due;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            one_due[j] = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (acc[i] && int'(dly[i*DW +: DW]) == 1 &&
                    int'(arr_dst[i*IW +: IW]) == j + 1)
                    one_due[j] = 1'b1;
            end
        end
    end

    // R6
    acc_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc & drop) == '0);

    // R4
    direct_sched_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct & sched_vld) == '0);

    for (genvar i = 0; i < N; i++) begin : g_in
        // R2
        idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !arr_vld[i] |-> (!acc[i] && !drop[i]));
        // R10
        delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            acc[i] |-> (int'(dly[i*DW +: DW]) <= N));
    end

    for (genvar j = 0; j < N; j++) begin : g_o
        // R9
        delay1_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            one_due[j] |=> rtn_vld[j]);
    end

endmodule

bind dlb_sched dlb_sched_chk #(.N(N), .IW(IW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_vld   (arr_vld),
    .arr_dst   (arr_dst),
    .acc       (acc),
    .drop      (drop),
    .direct    (direct),
    .sched_vld (sched_vld),
    .dly       (dly),
    .rtn_vld   (rtn_vld)
);

// File: tb/dlb_sched_tb.sv
`timescale 1ns/1ps
module dlb_sched_tb;

    localparam int N  = 4;
    localparam int IW = 3;
    localparam int DW = 3;
    localparam int SW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    arr_vld = '0;
    logic [N*IW-1:0] arr_dst = '0;
    logic [N-1:0]    acc, drop, direct, sched_vld, rtn_vld;
    logic [N*DW-1:0] dly;
    logic [N*SW-1:0] sched_wl;
    logic [N*IW-1:0] dir_wl, rtn_src, rtn_wl;

    always #4 clk = ~clk;

    dlb_sched #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_dst(arr_dst),
        .acc(acc), .drop(drop), .direct(direct), .sched_vld(sched_vld),
        .dly(dly), .sched_wl(sched_wl), .dir_wl(dir_wl),
        .rtn_vld(rtn_vld), .rtn_src(rtn_src), .rtn_wl(rtn_wl)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int occ_m [N];
    bit due_v [N][64];
    int due_s [N][64];
    int slot = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (slot %0d)", tag, act, exp, slot);
        end
    endtask

    function automatic logic [N*IW-1:0] pk(input int a0, input int a1, input int a2, input int a3);
        return {IW'(a3), IW'(a2), IW'(a1), IW'(a0)};
    endfunction

    task automatic run_slot(input logic [N-1:0] v, input logic [N*IW-1:0] d);
        logic [N-1:0]    e_acc, e_drop, e_dir, e_sv, e_rv;
        logic [N*DW-1:0] e_dly;
        logic [N*SW-1:0] e_sw;
        logic [N*IW-1:0] e_dw, e_rs, e_rw;
        int rank [N];
        int cnt  [N];
        @(negedge clk);
        arr_vld = v;
        arr_dst = d;
        #2;
        e_acc = '0; e_drop = '0; e_dir = '0; e_sv = '0; e_rv = '0;
        e_dly = '0; e_sw = '0; e_dw = '0; e_rs = '0; e_rw = '0;
        for (int j = 0; j < N; j++) begin
            rank[j] = 0;
            cnt[j]  = 0;
        end
        for (int j = 0; j < N; j++) begin
            if (due_v[j][slot % 64]) begin
                e_rv[j] = 1'b1;
                e_rs[j*IW +: IW] = IW'(due_s[j][slot % 64] + 1);
                e_rw[j*IW +: IW] = IW'(((due_s[j][slot % 64] + j) % N) + 1);
                due_v[j][slot % 64] = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) begin
            int dd;
            dd = int'(d[i*IW +: IW]);
            if (v[i] && dd >= 1 && dd <= N) begin
                int j;
                int k;
                j = dd - 1;
                k = occ_m[j] + rank[j];
                rank[j]++;
                cnt[j]++;
                if (k <= N) begin
                    e_acc[i] = 1'b1;
                    e_dly[i*DW +: DW] = DW'(k);
                    if (k == 0) begin
                        e_dir[i] = 1'b1;
                        e_dw[i*IW +: IW] = IW'(((i + j) % N) + 1);
                    end else begin
                        e_sv[i] = 1'b1;
                        e_sw[i*SW +: SW] = SW'(((N + i + k - 1) % (2 * N)) + 1);
                        due_v[j][(slot + k) % 64] = 1'b1;
                        due_s[j][(slot + k) % 64] = i;
                    end
                end else begin
                    e_drop[i] = 1'b1;
                end
            end
        end
        chk("R2 R3 accept",     64'(acc),      64'(e_acc));
        chk("R6 drop",          64'(drop),     64'(e_drop));
        chk("R3 R5 R10 delay",  64'(dly),      64'(e_dly));
        chk("R4 direct",        64'(direct),   64'(e_dir));
        chk("R4 sched_vld",     64'(sched_vld),64'(e_sv));
        chk("R7 sched_wl",      64'(sched_wl), 64'(e_sw));
        chk("R8 dir_wl",        64'(dir_wl),   64'(e_dw));
        chk("R9 rtn_vld",       64'(rtn_vld),  64'(e_rv));
        chk("R9 rtn_src",       64'(rtn_src),  64'(e_rs));
        chk("R9 rtn_wl",        64'(rtn_wl),   64'(e_rw));
        for (int j = 0; j < N; j++) begin
            int t;
            t = occ_m[j] + cnt[j] - 1;
            if (t < 0) t = 0;
            if (t > N) t = N;
            occ_m[j] = t;
        end
        slot++;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            occ_m[j] = 0;
            for (int s = 0; s < 64; s++) begin
                due_v[j][s] = 1'b0;
                due_s[j][s] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1 reset rtn_vld", 64'(rtn_vld), 64'(0));
        chk("R1 reset acc",     64'(acc),     64'(0));
        run_slot('0, '0);
        // R1 R4 R8: lone packet after reset goes direct
        run_slot(4'b0001, pk(1, 0, 0, 0));
        // R3: four requests to output 2 -> delays 0..3
        run_slot(4'b1111, pk(2, 2, 2, 2));
        // R6: second burst overflows output 2
        run_slot(4'b1111, pk(2, 2, 2, 2));
        // R2: invalid destinations and valid-low requests
        run_slot(4'b0111, pk(0, 5, 7, 1));
        run_slot(4'b0000, pk(1, 2, 3, 4));
        // R7 R9: prepare output 4 at occupancy 3, then input 3 with delay 3
        run_slot(4'b1111, pk(4, 4, 4, 4));
        run_slot(4'b0100, pk(0, 0, 4, 0));
        for (int n = 0; n < 8; n++) run_slot('0, '0);
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [N*IW-1:0] d;
            for (int i = 0; i < N; i++) d[i*IW +: IW] = IW'($urandom % 6);
            run_slot(N'($urandom), d);
        end
        for (int n = 0; n < 8; n++) run_slot('0, '0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule